// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block selects the access address for one port of a synchronous dual-port memory. On every rising clock edge it chooses one of four sources for the address that the array uses next. It can take the external address bus as a new base. It can step a stored burst counter forward by one. It can keep the counter where it is. Or it can return to the base address from the most recent strobe, with no idle cycle in between.

Only the low `ADDR_W-1` bits take part in counting. The most significant address bit always follows the external bus. A one-cycle wrap flag tells the surrounding logic when the counter has rolled over, so that logic can toggle the top bit itself.

A second copy of the address, the tag, is delayed by one extra cycle when the `PIPE` parameter is 1. This lines it up with pipelined read data.

Top module: `burst_addr_gen`

## Requirements
- R1: When `strobe_n` is 0 at a rising edge, `int_addr` equals `ext_addr` after that edge, and `src_ext` is 1. The low `ADDR_W-1` bits of `ext_addr` become both the counter value and the stored base.
- R2: When `strobe_n` is 1, `repeat_n` is 1 and `count_n` is 0 at an edge, the low bits of `int_addr` become the previous low bits plus one, and `src_ext` is 0.
- R3: When `strobe_n`, `repeat_n` and `count_n` are all 1 at an edge, the low bits of `int_addr` are unchanged.
- R4: When `strobe_n` is 1 and `repeat_n` is 0 at an edge, the low bits of `int_addr` become the base captured by the latest strobe. The stored base is not changed by this.
- R5: The sources have a fixed priority. Strobe overrides repeat and count. Repeat overrides count. Count overrides hold.
- R6: The low bits wrap from all ones (7FFFF with the default width) to zero. Bit `ADDR_W-1` of `int_addr` equals bit `ADDR_W-1` of `ext_addr` sampled at the same edge, in every mode.
- R7: `wrap` is 1 for exactly the one cycle after an edge where the counter advanced from all ones. It is 0 at every other time.
- R8: While `rst` is 1 at an edge, `int_addr`, `tag_addr`, `src_ext` and `wrap` read 0, and the counter and base are cleared. After reset, a hold or a repeat yields low bits of 0.
- R9: With `PIPE`=0, `tag_addr` equals `int_addr`. With `PIPE`=1, `tag_addr` equals the `int_addr` value from one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External address bus |
| strobe_n | input | 1 | Active-low address strobe: load external address |
| count_n | input | 1 | Active-low count enable |
| repeat_n | input | 1 | Active-low repeat: return to last strobed base |
| int_addr | output | ADDR_W | Access address for this cycle |
| src_ext | output | 1 | 1 when the access address came from the external bus |
| wrap | output | 1 | One-cycle pulse after the counter rolls over |
| tag_addr | output | ADDR_W | Access address delayed by PIPE cycles |

## Verification
The hardest case to reach is the counter rolling over. From a random base, a random walk almost never steps the counter all the way to all ones. The bench therefore strobes in bases just below the top and then counts across the boundary, while changing the top external bit to confirm it is never incremented. Repeat is driven after long mixed bursts and together with strobe and count, which checks that the base survives and that priority holds.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20,
  parameter int PIPE   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              count_n,
  input  logic              repeat_n,
  output logic [ADDR_W-1:0] int_addr,
  output logic              src_ext,
  output logic              wrap,
  output logic [ADDR_W-1:0] tag_addr
);
  localparam int CNT_W = ADDR_W - 1;

  logic [CNT_W-1:0] cnt_q, base_q, cnt_d;
  logic             top_q;

  wire sel_ld  = !strobe_n;
  wire sel_rp  = strobe_n && !repeat_n;
  wire sel_inc = strobe_n && repeat_n && !count_n;

  assign cnt_d = sel_ld  ? ext_addr[CNT_W-1:0] :
                 sel_rp  ? base_q :
                 sel_inc ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      base_q  <= '0;
      top_q   <= 1'b0;
      src_ext <= 1'b0;
      wrap    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      top_q   <= ext_addr[ADDR_W-1];
      src_ext <= sel_ld;
      wrap    <= sel_inc && (&cnt_q);
      if (sel_ld) base_q <= ext_addr[CNT_W-1:0];
    end
  end

  assign int_addr = {top_q, cnt_q};

  generate
    if (PIPE != 0) begin : g_pipe
      logic [ADDR_W-1:0] tag_q;
      always_ff @(posedge clk) begin
        if (rst) tag_q <= '0;
        else     tag_q <= int_addr;
      end
      assign tag_addr = tag_q;

      AST_TAG_DELAY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> tag_addr == $past(int_addr)); // R9
    end else begin : g_flow
      assign tag_addr = int_addr;
    end
  endgenerate

  AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (rst)
    !rst && !strobe_n |=> int_addr == $past(ext_addr) && src_ext); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !rst && sel_inc |=> int_addr[CNT_W-1:0] == $past(int_addr[CNT_W-1:0]) + 1'b1); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !rst && strobe_n && repeat_n && count_n |=> $stable(int_addr[CNT_W-1:0])); // R3
  AST_REPEAT_BASE: assert property (@(posedge clk) disable iff (rst)
    !rst && sel_rp |=> int_addr[CNT_W-1:0] == $past(base_q) && $stable(base_q)); // R4
  AST_TOP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !rst |=> int_addr[ADDR_W-1] == $past(ext_addr[ADDR_W-1])); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |-> int_addr[CNT_W-1:0] == '0 && !src_ext); // R7
  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap); // R7
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] ext = '0;
  logic        strobe_n = 1'b1, count_n = 1'b1, repeat_n = 1'b1;
  logic [19:0] int_addr, tag_addr, int_addr_p, tag_addr_p;
  logic        src_ext, wrap, src_ext_p, wrap_p;

  int checks = 0, errors = 0;
  logic [18:0] m_cnt = '0, m_base = '0;
  logic [19:0] m_addr = '0, m_prev = '0;
  logic        m_src = 1'b0, m_wrap = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(20), .PIPE(0)) uut (
    .clk(clk), .rst(rst), .ext_addr(ext), .strobe_n(strobe_n), .count_n(count_n),
    .repeat_n(repeat_n), .int_addr(int_addr), .src_ext(src_ext), .wrap(wrap),
    .tag_addr(tag_addr));

  burst_addr_gen #(.ADDR_W(20), .PIPE(1)) uut_p (
    .clk(clk), .rst(rst), .ext_addr(ext), .strobe_n(strobe_n), .count_n(count_n),
    .repeat_n(repeat_n), .int_addr(int_addr_p), .src_ext(src_ext_p), .wrap(wrap_p),
    .tag_addr(tag_addr_p));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string mode_of(logic s, logic r, logic c);
    if (!s) return "R1";
    if (!r) return "R4";
    if (!c) return "R2";
    return "R3";
  endfunction

  task automatic step(logic [19:0] e, logic s, logic r, logic c, string tag = "");
    string req;
    @(negedge clk);
    ext = e; strobe_n = s; repeat_n = r; count_n = c;
    @(posedge clk); #1;
    req = (tag != "") ? tag : mode_of(s, r, c);
    m_wrap = s && r && !c && (m_cnt == 19'h7FFFF);
    if (!s)      begin m_cnt = e[18:0]; m_base = e[18:0]; end
    else if (!r) m_cnt = m_base;
    else if (!c) m_cnt = m_cnt + 1'b1;
    m_src  = !s;
    m_prev = m_addr;
    m_addr = {e[19], m_cnt};
    chk(req, "int_addr", {12'b0, int_addr}, {12'b0, m_addr});
    chk(req, "src_ext", {31'b0, src_ext}, {31'b0, m_src});
    chk((tag != "") ? tag : "R7", "wrap", {31'b0, wrap}, {31'b0, m_wrap});
    chk("R9", "tag_flow", {12'b0, tag_addr}, {12'b0, m_addr});
    chk("R9", "tag_pipe", {12'b0, tag_addr_p}, {12'b0, m_prev});
    chk(req, "int_addr_pipe_inst", {12'b0, int_addr_p}, {12'b0, m_addr});
  endtask

  initial begin
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "int_addr", {12'b0, int_addr}, 32'h0);
    chk("R8", "src_ext", {31'b0, src_ext}, 32'h0);
    chk("R8", "wrap", {31'b0, wrap}, 32'h0);
    chk("R8", "tag_pipe", {12'b0, tag_addr_p}, 32'h0);
    @(negedge clk); rst = 1'b0;
    step(20'h00000, 1, 1, 1, "R8");
    step(20'h00000, 1, 0, 1, "R8");
    step(20'h00000, 1, 1, 0, "R8");
    step(20'h00000, 1, 0, 0, "R8");

    step(20'h12345, 0, 1, 1);
    for (int i = 0; i < 5; i++) step(20'h00000, 1, 1, 0);
    step(20'h00000, 1, 1, 1);
    step(20'h00000, 1, 1, 1);
    step(20'h00000, 1, 0, 1);
    step(20'h00000, 1, 0, 0, "R5");
    step(20'h0ABCD, 0, 0, 0, "R5");
    step(20'h00000, 1, 1, 0);
    step(20'h00000, 1, 0, 1);

    step(20'h7FFFD, 0, 1, 1, "R6");
    step(20'h00000, 1, 1, 0, "R6");
    step(20'h80000, 1, 1, 0, "R6");
    step(20'h80000, 1, 1, 0, "R6");
    step(20'h80000, 1, 1, 0, "R6");
    step(20'h80000, 1, 1, 1, "R6");
    step(20'hFFFFF, 0, 1, 0, "R6");
    step(20'h80000, 1, 1, 0, "R6");
    step(20'h00000, 1, 0, 1, "R6");
    step(20'h7FFFF, 0, 1, 1, "R7");
    step(20'h7FFFF, 1, 0, 0, "R7");
    step(20'h00000, 1, 1, 1, "R7");

    for (int i = 0; i < 3000; i++) begin
      logic [19:0] e;
      logic s, r, c;
      e = 20'($urandom);
      if (($urandom % 4) == 0) e[18:0] = 19'h7FFFF - 19'($urandom % 4);
      s = ($urandom % 8) != 0;
      r = ($urandom % 6) != 0;
      c = ($urandom % 3) == 0;
      step(e, s, r, c);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule